// File: doc/BRIEF.md
# Multi-format audio serial port receiver

This block deserialises stereo PCM audio from a three-wire serial link: a bit clock, a channel-select clock, and a data line. It runs as a slave. Both clocks come from outside, and the bit clock is the block's own clock. Each completed stereo frame produces a 24-bit left word, a 24-bit right word and a one-cycle strobe. The data line is sampled on the rising bit-clock edge, and channel-clock transitions are detected on that same edge.

A 3-bit format code selects one of four framings: I2S, left-justified, right-justified or frame-pulse (DSP) framing. A 2-bit code selects a sample width of 24, 20 or 16 bits. Both codes may be changed at any time, but the receiver only loads them at a frame boundary, so a frame in progress always finishes under the settings it started with. After reset the receiver runs a clear period of twenty channel-clock periods. During that period it keeps its outputs at zero and raises a busy flag.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted, busy is 1, valid is 0, and both output words are zero.
- R2: Format code 000 (the reset default) is I2S. The channel clock low selects the left channel and high selects the right. The MSB is the second bit sampled after each channel-clock edge.
- R3: Format code 001 is left-justified. The MSB is the first bit sampled with the new channel-clock level.
- R4: Format code 010 is right-justified. The LSB is the last bit before the next channel-clock edge, and the selected width sets how far back the MSB lies.
- R5: Format code 011 is frame-pulse framing. The channel clock is high for one bit at the frame start. The left MSB is the next bit, and the right word follows immediately after the left LSB.
- R6: Width code 00 selects 24 bits, 01 selects 20 and 10 selects 16. Narrower samples appear MSB-aligned at bit 23 of the output word, and the lower bits are zero.
- R7: valid pulses for exactly one cycle after each right word completes. Both words update in that cycle and hold until the next pulse.
- R8: After reset is released, busy stays high, outputs stay zero and valid stays low until the twentieth falling edge of the channel clock. After that, busy stays low.
- R9: A change of format or width code takes effect only at the next frame boundary. In I2S, left-justified and right-justified framing that boundary is the falling channel-clock edge. In frame-pulse framing it is the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Channel clock, or frame pulse in frame-pulse framing |
| sdata | input | 1 | Serial sample data, MSB first |
| mode | input | 3 | Framing format code |
| width | input | 2 | Sample width code |
| left_word | output | 24 | Last received left sample, MSB-aligned |
| right_word | output | 24 | Last received right sample, MSB-aligned |
| valid | output | 1 | One-cycle strobe when a new word pair is presented |
| busy | output | 1 | High during the post-reset clear period |

## Verification
The properties assume a free-running bit clock with at least 17 bits between channel-clock edges, so that two strobes can never fall in adjacent cycles. They also assume that the channel clock and the data change only away from the rising bit-clock edge. The stimulus meets these assumptions by driving every input on the falling edge and sending 64-bit frames, with 32-bit halves in the standard formats. It moves into frame-pulse framing only through a fresh reset. This matters because a frame-pulse stream's boundaries cannot be decoded under a standard framing. Format and width codes are changed in the middle of the right half of a frame, which leaves the current frame complete under its old settings.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int WORD_BITS    = 24,
  parameter int CLEAR_FRAMES = 20,
  parameter int POS_BITS     = 7
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 lrclk,
  input  logic                 sdata,
  input  logic [2:0]           mode,
  input  logic [1:0]           width,
  output logic [WORD_BITS-1:0] left_word,
  output logic [WORD_BITS-1:0] right_word,
  output logic                 valid,
  output logic                 busy
);

  localparam logic [2:0] FMT_I2S = 3'd0;
  localparam logic [2:0] FMT_LJ  = 3'd1;
  localparam logic [2:0] FMT_RJ  = 3'd2;
  localparam logic [2:0] FMT_DSP = 3'd3;
  localparam int CLR_BITS = $clog2(CLEAR_FRAMES + 1);
  localparam logic [POS_BITS-1:0] POS_MAX = '1;
  localparam logic [POS_BITS-1:0] POS_ONE = POS_BITS'(1);

  logic                 lr_q;
  logic [2:0]           fmt;
  logic [1:0]           wsel;
  logic [POS_BITS-1:0]  pos_q;
  logic [WORD_BITS-1:0] acc;
  logic [WORD_BITS-1:0] left_hold;
  logic [CLR_BITS-1:0]  clr_cnt;

  wire rise   = lrclk & ~lr_q;
  wire fall   = ~lrclk & lr_q;
  wire is_dsp = (fmt == FMT_DSP);
  wire is_rj  = (fmt == FMT_RJ);
  wire is_lj  = (fmt == FMT_LJ);

  wire boundary = is_dsp ? rise : fall;
  wire start    = is_dsp ? rise : (rise | fall);

  wire [POS_BITS-1:0] pos  = start ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + POS_ONE);
  wire [POS_BITS-1:0] lead = is_lj ? '0 : POS_ONE;
  wire [POS_BITS-1:0] idx  = pos - lead;
  wire                in_word = (pos >= lead) && (pos != POS_MAX);

  wire [POS_BITS-1:0] nbits = (wsel == 2'b01) ? POS_BITS'(20) :
                              (wsel == 2'b10) ? POS_BITS'(16) : POS_BITS'(WORD_BITS);

  wire first_end  = in_word && (idx == nbits - POS_ONE);
  wire second_end = in_word && (idx == (nbits << 1) - POS_ONE);

  wire left_done  = is_rj ? rise : is_dsp ? first_end  : (first_end && !lrclk);
  wire right_done = is_rj ? fall : is_dsp ? second_end : (first_end && lrclk);

  wire [WORD_BITS-1:0] word_src = is_rj ? acc : {acc[WORD_BITS-2:0], sdata};
  wire [POS_BITS-1:0]  pad      = POS_BITS'(WORD_BITS) - nbits;
  wire [WORD_BITS-1:0] word_now = word_src << pad;

  assign busy = (clr_cnt != CLR_BITS'(CLEAR_FRAMES));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q       <= 1'b0;
      fmt        <= FMT_I2S;
      wsel       <= 2'b00;
      pos_q      <= POS_MAX;
      acc        <= '0;
      left_hold  <= '0;
      clr_cnt    <= '0;
      left_word  <= '0;
      right_word <= '0;
      valid      <= 1'b0;
    end else begin
      lr_q  <= lrclk;
      pos_q <= pos;
      acc   <= {acc[WORD_BITS-2:0], sdata};
      if (boundary) begin
        fmt  <= mode;
        wsel <= width;
      end
      if (busy && fall) clr_cnt <= clr_cnt + CLR_BITS'(1);
      if (left_done) left_hold <= word_now;
      valid <= !busy && right_done;
      if (!busy && right_done) begin
        left_word  <= left_hold;
        right_word <= word_now;
      end
    end
  end

endmodule

// File: rtl/audio_serial_rx_checker.sv
module audio_serial_rx_checker #(
  parameter int WORD_BITS = 24
) (
  input logic                 bclk,
  input logic                 rst_n,
  input logic                 valid,
  input logic                 busy,
  input logic [WORD_BITS-1:0] left_word,
  input logic [WORD_BITS-1:0] right_word
);

  always @(posedge bclk) begin
    if (!rst_n)
      a_r1_reset_quiet: assert (busy && !valid && left_word == '0 && right_word == '0);
  end

  a_r7_one_cycle_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
    valid |=> !valid);

  a_r7_words_held: assert property (@(posedge bclk) disable iff (!rst_n)
    !valid |-> ($stable(left_word) && $stable(right_word)));

  a_r8_quiet_while_busy: assert property (@(posedge bclk) disable iff (!rst_n)
    busy |-> (!valid && left_word == '0 && right_word == '0));

  a_r8_clear_once: assert property (@(posedge bclk) disable iff (!rst_n)
    !busy |=> !busy);

endmodule

bind audio_serial_rx audio_serial_rx_checker #(.WORD_BITS(WORD_BITS)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .valid(valid), .busy(busy),
  .left_word(left_word), .right_word(right_word)
);

// File: tb/audio_serial_rx_test.sv
`timescale 1ns/1ps
module audio_serial_rx_test;

  logic        bclk = 1'b0;
  logic        rst_n, lrclk, sdata;
  logic [2:0]  mode;
  logic [1:0]  width;
  logic [23:0] left_word, right_word;
  logic        valid, busy;

  int vectors = 0;
  int fails = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] hold_l = '0;
  logic [23:0] hold_r = '0;

  always #2.5 bclk = ~bclk;

  audio_serial_rx uut (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata),
    .mode(mode), .width(width), .left_word(left_word), .right_word(right_word),
    .valid(valid), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int wval(input logic [1:0] c);
    case (c)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] align(input logic [23:0] s, input int w);
    logic [23:0] m = '0;
    for (int j = 0; j < w; j++) m[23-j] = s[w-1-j];
    return m;
  endfunction

  task automatic send_frame(input logic [2:0] m, input logic [1:0] wc,
                            input logic [23:0] l, input logic [23:0] r,
                            input bit push, input string tag,
                            input logic [2:0] nm, input logic [1:0] nwc);
    int w = wval(wc);
    if (push) begin
      exp_q.push_back({align(l, w), align(r, w)});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 64; i++) begin
      logic lr;
      logic d;
      logic [23:0] s;
      int j;
      d = 1'b0;
      if (m == 3'd3) begin
        lr = (i == 0);
        if (i >= 1 && i <= w) d = l[w-i];
        else if (i > w && i <= 2*w) d = r[2*w-i];
      end else begin
        lr = (i >= 32);
        j  = i % 32;
        s  = lr ? r : l;
        case (m)
          3'd1:    if (j < w) d = s[w-1-j];
          3'd2:    if (j >= 32 - w) d = s[31-j];
          default: if (j >= 1 && j <= w) d = s[w-j];
        endcase
      end
      @(negedge bclk);
      lrclk = lr;
      sdata = d;
      if (i == 40) begin
        mode  = nm;
        width = nwc;
      end
      if (i == 20)
        check(left_word == hold_l && right_word == hold_r, "R7", "words held between strobes",
              {left_word, right_word}, {hold_l, hold_r});
    end
  endtask

  always @(negedge bclk) begin
    if (rst_n === 1'b1 && valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "strobe with nothing expected", {left_word, right_word}, 48'h0);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({left_word, right_word} == e, t, "received word pair", {left_word, right_word}, e);
        hold_l = e[47:24];
        hold_r = e[23:0];
      end
    end
  end

  initial begin
    repeat (100000) @(posedge bclk);
    check(1'b0, "R7", "watchdog expired", 48'h0, 48'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lrclk = 1'b0; sdata = 1'b0; mode = 3'd0; width = 2'b00;
    repeat (4) @(negedge bclk);
    check(busy == 1'b1 && valid == 1'b0, "R1", "busy/valid in reset",
          {46'h0, busy, valid}, {46'h0, 2'b10});
    check(left_word == '0 && right_word == '0, "R1", "words in reset",
          {left_word, right_word}, 48'h0);
    rst_n = 1'b1;

    for (int f = 0; f < 20; f++)
      send_frame(3'd0, 2'b00, 24'($urandom), 24'($urandom), 1'b0, "R8", 3'd0, 2'b00);
    check(busy == 1'b1, "R8", "busy before 20th boundary", {47'h0, busy}, 48'h1);
    check(left_word == '0 && right_word == '0, "R8", "words zero while busy",
          {left_word, right_word}, 48'h0);
    send_frame(3'd0, 2'b00, 24'h123456, 24'h89ABCD, 1'b1, "R8", 3'd0, 2'b00);
    check(busy == 1'b0, "R8", "busy after 20th boundary", {47'h0, busy}, 48'h0);

    send_frame(3'd0, 2'b00, 24'hFFFFFF, 24'h000001, 1'b1, "R2", 3'd0, 2'b00);
    send_frame(3'd0, 2'b00, 24'h800000, 24'h7FFFFF, 1'b1, "R2", 3'd0, 2'b00);
    send_frame(3'd0, 2'b00, 24'($urandom), 24'($urandom), 1'b1, "R2", 3'd0, 2'b00);
    send_frame(3'd0, 2'b00, 24'hA5A5A5, 24'h5A5A5A, 1'b1, "R9", 3'd0, 2'b01);
    send_frame(3'd0, 2'b01, 24'h0FFFFF, 24'h080001, 1'b1, "R6", 3'd0, 2'b01);
    send_frame(3'd0, 2'b01, 24'($urandom), 24'($urandom), 1'b1, "R9", 3'd0, 2'b10);
    send_frame(3'd0, 2'b10, 24'h00FFFF, 24'h008001, 1'b1, "R6", 3'd0, 2'b10);
    send_frame(3'd0, 2'b10, 24'($urandom), 24'($urandom), 1'b1, "R9", 3'd1, 2'b00);

    send_frame(3'd1, 2'b00, 24'hC00003, 24'h3FFFFC, 1'b1, "R3", 3'd1, 2'b00);
    send_frame(3'd1, 2'b00, 24'($urandom), 24'($urandom), 1'b1, "R3", 3'd1, 2'b10);
    send_frame(3'd1, 2'b10, 24'h00F00F, 24'h000FF0, 1'b1, "R3", 3'd2, 2'b00);

    send_frame(3'd2, 2'b00, 24'hF00001, 24'h800003, 1'b1, "R4", 3'd2, 2'b00);
    send_frame(3'd2, 2'b00, 24'($urandom), 24'($urandom), 1'b1, "R4", 3'd2, 2'b01);
    send_frame(3'd2, 2'b01, 24'h0C0003, 24'h0F0F0F, 1'b1, "R4", 3'd2, 2'b10);
    send_frame(3'd2, 2'b10, 24'h00C001, 24'h00FFFE, 1'b1, "R4", 3'd2, 2'b10);
    send_frame(3'd2, 2'b10, 24'h0, 24'h0, 1'b0, "R4", 3'd2, 2'b10);
    check(exp_q.size() == 0, "R4", "pending pairs before second reset",
          48'(exp_q.size()), 48'h0);

    @(negedge bclk);
    rst_n = 1'b0; lrclk = 1'b0; sdata = 1'b0; mode = 3'd3; width = 2'b00;
    hold_l = '0; hold_r = '0;
    exp_q.delete(); tag_q.delete();
    repeat (3) @(negedge bclk);
    check(busy == 1'b1 && valid == 1'b0 && left_word == '0, "R1", "state in second reset",
          {23'h0, busy, left_word}, {23'h0, 1'b1, 24'h0});
    rst_n = 1'b1;
    for (int f = 0; f < 19; f++)
      send_frame(3'd3, 2'b00, 24'($urandom), 24'($urandom), 1'b0, "R8", 3'd3, 2'b00);
    check(busy == 1'b1, "R8", "busy before 20th pulse boundary", {47'h0, busy}, 48'h1);
    send_frame(3'd3, 2'b00, 24'h876543, 24'h012345, 1'b1, "R5", 3'd3, 2'b00);
    send_frame(3'd3, 2'b00, 24'hFFFFFE, 24'h800001, 1'b1, "R5", 3'd3, 2'b00);
    send_frame(3'd3, 2'b00, 24'($urandom), 24'($urandom), 1'b1, "R9", 3'd3, 2'b10);
    send_frame(3'd3, 2'b10, 24'h00FFFF, 24'h00C003, 1'b1, "R6", 3'd3, 2'b10);
    send_frame(3'd3, 2'b10, 24'($urandom), 24'($urandom), 1'b1, "R5", 3'd3, 2'b10);
    repeat (70) @(negedge bclk);
    check(exp_q.size() == 0, "R5", "pairs left unreceived", 48'(exp_q.size()), 48'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule